// File: doc/BRIEF.md
# Two-Bit Priority Level Stack

This block keeps the current interrupt priority of a small processor core, together with a short history of earlier priorities, in a single byte. The byte acts as a four-deep stack of 2-bit levels. Entering a new level shifts the older levels up by one slot. Leaving a level rotates the byte back, so the entry that was pushed out of the low slot returns at the top. A second byte of the same shape records whether the core runs in system or user mode. Its current mode can be queried into a carry flag.

The whole priority byte can be saved to a byte-wide stack in memory and loaded back from it, through a 16-bit stack pointer that the block owns. A return-from-interrupt command restores the priority byte from memory and then fetches a 16-bit return address. That takes three consecutive memory reads, during which the block reports itself busy. The core issues one command per cycle through a strobe and an 8-bit opcode. Memory read data is expected in the same cycle as the read strobe.

Top module: `prio_level_stack`

## Requirements
- R1: After reset the priority byte, the mode byte and the carry output are 0x00/0, the stack pointer equals the parameter SP_INIT (default 0x0080), and busy, retValid, memRdEn and memWrEn are low.
- R2: A set-level opcode matches the pattern 8'b010LL110 (0x46, 0x4E, 0x56, 0x5E). It makes the priority byte {old[5:0], LL}, so LL = opcode[4:3] enters the low slot and the top slot is dropped.
- R3: The priority restore opcode 0x01 rotates the priority byte right by two bits: the new byte is {old[1:0], old[7:2]}.
- R4: The push opcode 0x02 decrements the stack pointer by one. In the same cycle it writes the priority byte to the decremented address, with memWrEn high for exactly that cycle.
- R5: The pop opcode 0x03 reads memory at the stack pointer, loads the byte read into the priority byte, and increments the stack pointer by one.
- R6: The return opcode 0x04 reads three bytes at stack pointer addresses P, P+1 and P+2 in three consecutive cycles. The first byte goes to the priority byte. retAddr becomes {third, second}, and retValid is high for the one cycle after the third read. busy is high in the second and third cycles, and the stack pointer ends at P+3.
- R7: The set-user opcode 0x05 makes the mode byte {old[5:0], 2'b01}.
- R8: The mode restore opcode 0x06 rotates the mode byte right by two bits: {old[1:0], old[7:2]}.
- R9: The read-mode opcode 0x07 sets carryOut to bit 0 of the mode byte. No other command changes carryOut.
- R10: A command strobed while busy is high, or any opcode not listed above (for example 0xFF or 0x47), has no effect. It changes neither byte, the carry nor the stack pointer, and raises no memory strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 8 | Command opcode |
| busy | output | 1 | High while a return sequence is still reading |
| memAddr | output | 16 | Byte address toward the memory stack |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Byte to write (the priority byte) |
| memRdData | input | 8 | Byte read, valid in the same cycle as memRdEn |
| prioLevel | output | 8 | Priority byte; bits 1:0 hold the current level |
| modeReg | output | 8 | Mode byte; bit 0 is set in user mode |
| carryOut | output | 1 | Carry flag from the last read-mode command |
| stackPtr | output | 16 | Current stack pointer |
| retAddr | output | 16 | Return address from the last return sequence |
| retValid | output | 1 | One-cycle pulse when retAddr is updated |

## Verification
The level stack is driven by all four set-level codes in turn, so that each 2-bit pattern is seen entering the low slot and then being discarded from the top. Two restores follow that must bring the earlier bytes back exactly. A set-user, read-mode and restore sequence on the mode byte is chosen so that the carry alternates, which separates a rotate from a plain shift. It also shows that the 01 tag wraps to the top. Push and pop are checked against the addresses written and read. A return sequence is checked with a set-level command strobed while busy, and undefined opcodes are checked for the absence of any change.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int LEVEL_W = 2;
  localparam int DEPTH   = 4;
  localparam int REG_W   = LEVEL_W * DEPTH;
  localparam int SP_W    = 16;
  localparam int OP_W    = 8;

  localparam logic [OP_W-1:0] SETLVL_MASK = 8'hE7;
  localparam logic [OP_W-1:0] SETLVL_BASE = 8'h46;
  localparam logic [OP_W-1:0] OP_RESTORE  = 8'h01;
  localparam logic [OP_W-1:0] OP_PUSH     = 8'h02;
  localparam logic [OP_W-1:0] OP_POP      = 8'h03;
  localparam logic [OP_W-1:0] OP_RETURN   = 8'h04;
  localparam logic [OP_W-1:0] OP_SETUSER  = 8'h05;
  localparam logic [OP_W-1:0] OP_MODERES  = 8'h06;
  localparam logic [OP_W-1:0] OP_RDMODE   = 8'h07;

  localparam logic [LEVEL_W-1:0] USER_TAG = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RET_LO = 2'd1,
    ST_RET_HI = 2'd2
  } seqState_t;

  typedef struct packed {
    logic               ipShift;
    logic               ipRot;
    logic               ipLoad;
    logic               modeShift;
    logic               modeRot;
    logic               carryLoad;
    logic               spDec;
    logic               spInc;
    logic               memRd;
    logic               memWr;
    logic               loLoad;
    logic               retLoad;
    logic [LEVEL_W-1:0] level;
  } dpStrobe_t;
endpackage

// File: rtl/pls_pair_stack.sv
module pls_pair_stack #(
  parameter int LW = 2,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          shiftEn,
  input  logic          rotEn,
  input  logic          loadEn,
  input  logic [LW-1:0] shiftVal,
  input  logic [RW-1:0] loadVal,
  output logic [RW-1:0] q
);
  logic [RW-1:0] qNext;

  always_comb begin
    qNext = q;
    if (loadEn)       qNext = loadVal;
    else if (shiftEn) qNext = {q[RW-LW-1:0], shiftVal};
    else if (rotEn)   qNext = {q[LW-1:0], q[RW-1:LW]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= qNext;
  end

  // R2, R7
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !loadEn) |=> q[LW-1:0] == $past(shiftVal));

  // R3, R8
  rotate_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rotEn && !shiftEn && !loadEn) |=> q[RW-1:RW-LW] == $past(q[LW-1:0]));
endmodule

// File: rtl/pls_ctrl.sv
module pls_ctrl
  import pls_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  output logic            busy,
  output dpStrobe_t       strb
);
  seqState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    strb.level = cmdOp[4:3];
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          if ((cmdOp & SETLVL_MASK) == SETLVL_BASE) begin
            strb.ipShift = 1'b1;
          end else begin
            case (cmdOp)
              OP_RESTORE: strb.ipRot     = 1'b1;
              OP_PUSH: begin
                strb.spDec = 1'b1;
                strb.memWr = 1'b1;
              end
              OP_POP: begin
                strb.memRd  = 1'b1;
                strb.spInc  = 1'b1;
                strb.ipLoad = 1'b1;
              end
              OP_RETURN: begin
                strb.memRd  = 1'b1;
                strb.spInc  = 1'b1;
                strb.ipLoad = 1'b1;
                stateNext   = ST_RET_LO;
              end
              OP_SETUSER: strb.modeShift = 1'b1;
              OP_MODERES: strb.modeRot   = 1'b1;
              OP_RDMODE:  strb.carryLoad = 1'b1;
              default: ;
            endcase
          end
        end
      end
      ST_RET_LO: begin
        strb.memRd  = 1'b1;
        strb.spInc  = 1'b1;
        strb.loLoad = 1'b1;
        stateNext   = ST_RET_HI;
      end
      ST_RET_HI: begin
        strb.memRd   = 1'b1;
        strb.spInc   = 1'b1;
        strb.retLoad = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ipShift, strb.ipRot, strb.ipLoad, strb.modeShift,
              strb.modeRot, strb.carryLoad, strb.memWr}));

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.ipShift || strb.ipRot || strb.ipLoad || strb.modeShift ||
               strb.modeRot || strb.carryLoad || strb.memWr));

  // R6
  ret_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RET_LO) |=> (state == ST_RET_HI));
endmodule

// File: rtl/pls_dp.sv
module pls_dp
  import pls_pkg::*;
#(
  parameter logic [SP_W-1:0] SP_INIT = 16'h0080
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [REG_W-1:0] memRdData,
  output logic [SP_W-1:0]  memAddr,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [REG_W-1:0] memWrData,
  output logic [REG_W-1:0] prioLevel,
  output logic [REG_W-1:0] modeReg,
  output logic             carryOut,
  output logic [SP_W-1:0]  stackPtr,
  output logic [SP_W-1:0]  retAddr,
  output logic             retValid
);
  localparam int NSTK = 2;

  logic [SP_W-1:0]  spQ;
  logic [REG_W-1:0] loQ;
  logic             carryQ;
  logic [SP_W-1:0]  retQ;
  logic             retVldQ;

  logic [NSTK-1:0]            stkShift, stkRot, stkLoad;
  logic [NSTK-1:0][LEVEL_W-1:0] stkShVal;
  logic [NSTK-1:0][REG_W-1:0] stkLdVal, stkQ;

  assign stkShift = {strb.modeShift, strb.ipShift};
  assign stkRot   = {strb.modeRot,   strb.ipRot};
  assign stkLoad  = {1'b0,           strb.ipLoad};
  assign stkShVal = {USER_TAG,       strb.level};
  assign stkLdVal = {{REG_W{1'b0}},  memRdData};

  for (genvar i = 0; i < NSTK; i++) begin : gStk
    pls_pair_stack #(.LW(LEVEL_W), .RW(REG_W)) uStk (
      .clk     (clk),
      .rstN    (rstN),
      .shiftEn (stkShift[i]),
      .rotEn   (stkRot[i]),
      .loadEn  (stkLoad[i]),
      .shiftVal(stkShVal[i]),
      .loadVal (stkLdVal[i]),
      .q       (stkQ[i])
    );
  end

  assign prioLevel = stkQ[0];
  assign modeReg   = stkQ[1];

  assign memAddr   = strb.spDec ? (spQ - 1'b1) : spQ;
  assign memRdEn   = strb.memRd;
  assign memWrEn   = strb.memWr;
  assign memWrData = stkQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ     <= SP_INIT;
      loQ     <= '0;
      carryQ  <= 1'b0;
      retQ    <= '0;
      retVldQ <= 1'b0;
    end else begin
      if (strb.spDec)      spQ <= spQ - 1'b1;
      else if (strb.spInc) spQ <= spQ + 1'b1;
      if (strb.loLoad)    loQ <= memRdData;
      if (strb.carryLoad) carryQ <= stkQ[1][0];
      if (strb.retLoad)   retQ <= {memRdData, loQ};
      retVldQ <= strb.retLoad;
    end
  end

  assign carryOut = carryQ;
  assign stackPtr = spQ;
  assign retAddr  = retQ;
  assign retValid = retVldQ;

  // R4
  push_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> spQ == $past(memAddr));

  // R5, R6
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> spQ == $past(memAddr) + 1'b1);

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.carryLoad |=> $stable(carryQ));

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));
endmodule

// File: rtl/prio_level_stack.sv
module prio_level_stack
  import pls_pkg::*;
#(
  parameter logic [SP_W-1:0] SP_INIT = 16'h0080
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [OP_W-1:0]  cmdOp,
  output logic             busy,
  output logic [SP_W-1:0]  memAddr,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [REG_W-1:0] memWrData,
  input  logic [REG_W-1:0] memRdData,
  output logic [REG_W-1:0] prioLevel,
  output logic [REG_W-1:0] modeReg,
  output logic             carryOut,
  output logic [SP_W-1:0]  stackPtr,
  output logic [SP_W-1:0]  retAddr,
  output logic             retValid
);
  dpStrobe_t strb;

  pls_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .busy    (busy),
    .strb    (strb)
  );

  pls_dp #(.SP_INIT(SP_INIT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .prioLevel(prioLevel),
    .modeReg  (modeReg),
    .carryOut (carryOut),
    .stackPtr (stackPtr),
    .retAddr  (retAddr),
    .retValid (retValid)
  );
endmodule

// File: tb/prio_level_stack_test.sv
`timescale 1ns/1ps
module prio_level_stack_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOp = 8'h00;
  logic        busy, memRdEn, memWrEn, carryOut, retValid;
  logic [15:0] memAddr, stackPtr, retAddr;
  logic [7:0]  memWrData, memRdData, prioLevel, modeReg;

  logic [7:0] mem [256];
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  prio_level_stack uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData), .prioLevel(prioLevel),
    .modeReg(modeReg), .carryOut(carryOut), .stackPtr(stackPtr),
    .retAddr(retAddr), .retValid(retValid)
  );

  assign memRdData = mem[memAddr[7:0]];
  always @(posedge clk) if (memWrEn) mem[memAddr[7:0]] <= memWrData;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles=%0d expected fewer", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [7:0] op);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] ip;
    logic [7:0] md;
    logic       cy;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'h5E, 8'h03, 8'h00, 1'b0},  // R2 level 3
    '{8'h4E, 8'h0D, 8'h00, 1'b0},  // R2 level 1
    '{8'h56, 8'h36, 8'h00, 1'b0},  // R2 level 2
    '{8'h46, 8'hD8, 8'h00, 1'b0},  // R2 level 0
    '{8'h5E, 8'h63, 8'h00, 1'b0},  // R2 top pair dropped
    '{8'h01, 8'hD8, 8'h00, 1'b0},  // R3
    '{8'h01, 8'h36, 8'h00, 1'b0},  // R3
    '{8'h05, 8'h36, 8'h01, 1'b0},  // R7
    '{8'h07, 8'h36, 8'h01, 1'b1},  // R9
    '{8'h05, 8'h36, 8'h05, 1'b1},  // R7
    '{8'h06, 8'h36, 8'h41, 1'b1},  // R8
    '{8'h07, 8'h36, 8'h41, 1'b1},  // R9
    '{8'h06, 8'h36, 8'h50, 1'b1},  // R8
    '{8'h07, 8'h36, 8'h50, 1'b0},  // R9
    '{8'h06, 8'h36, 8'h14, 1'b0},  // R8
    '{8'h06, 8'h36, 8'h05, 1'b0},  // R8
    '{8'h07, 8'h36, 8'h05, 1'b1},  // R9
    '{8'hFF, 8'h36, 8'h05, 1'b1},  // R10 undefined
    '{8'h47, 8'h36, 8'h05, 1'b1}   // R10 near-miss code
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #5;
    chk("R1 prio", prioLevel, 8'h00);
    chk("R1 mode", modeReg, 8'h00);
    chk("R1 carry", carryOut, 1'b0);
    chk("R1 sp", stackPtr, 16'h0080);
    chk("R1 busy", busy, 1'b0);
    chk("R1 strobes", {retValid, memRdEn, memWrEn}, 3'b000);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doCmd(VEC[i].op);
      chk("R2/R3 table prio", prioLevel, VEC[i].ip);
      chk("R7/R8 table mode", modeReg, VEC[i].md);
      chk("R9 table carry", carryOut, VEC[i].cy);
      chk("R10 table sp", stackPtr, 16'h0080);
    end

    // R10 undefined opcode raises no memory strobe
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 8'hFF;
    #1;
    chk("R10 no strobe", {memRdEn, memWrEn}, 2'b00);
    cmdValid = 1'b0;

    // R4 push twice
    doCmd(8'h02);
    chk("R4 sp", stackPtr, 16'h007F);
    chk("R4 mem", mem[8'h7F], 8'h36);
    doCmd(8'h46);
    chk("R2 prio", prioLevel, 8'hD8);
    doCmd(8'h02);
    chk("R4 sp2", stackPtr, 16'h007E);
    chk("R4 mem2", mem[8'h7E], 8'hD8);
    doCmd(8'h01);
    chk("R3 prio", prioLevel, 8'h36);

    // R5 pop twice
    doCmd(8'h03);
    chk("R5 prio", prioLevel, 8'hD8);
    chk("R5 sp", stackPtr, 16'h007F);
    doCmd(8'h03);
    chk("R5 prio2", prioLevel, 8'h36);
    chk("R5 sp2", stackPtr, 16'h0080);

    // R6 return sequence with a command strobed while busy (R10)
    mem[8'h80] = 8'hA5; mem[8'h81] = 8'h34; mem[8'h82] = 8'h12;
    doCmd(8'h04);
    chk("R6 prio", prioLevel, 8'hA5);
    chk("R6 busy1", busy, 1'b1);
    chk("R6 sp1", stackPtr, 16'h0081);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 8'h5E;
    @(posedge clk); #1;
    chk("R6 busy2", busy, 1'b1);
    chk("R6 sp2", stackPtr, 16'h0082);
    chk("R6 retValid low", retValid, 1'b0);
    @(negedge clk);
    cmdOp = 8'h07;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    chk("R6 busy3", busy, 1'b0);
    chk("R6 sp3", stackPtr, 16'h0083);
    chk("R6 retValid", retValid, 1'b1);
    chk("R6 retAddr", retAddr, 16'h1234);
    chk("R10 busy ignored prio", prioLevel, 8'hA5);
    chk("R10 busy ignored carry", carryOut, 1'b1);
    @(posedge clk); #1;
    chk("R6 retValid pulse", retValid, 1'b0);
    chk("R6 retAddr held", retAddr, 16'h1234);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule